// File: doc/BRIEF.md
# Shift/Twist Test Pattern Decompressor

This block is a parallel pattern register placed in front of the inputs of a core under test. Each scan clock it may form a new test pattern from its own contents. One serial bit per cycle from the tester picks the update. Shift rotates the register as a plain ring. Twist rotates it with the bit that wraps around inverted, so the register counts as a Johnson counter. The tester streams these one-bit choices, and the register presents a fresh pattern to the core on every clock that carries a choice. The register outputs drive the core directly, with no decoding logic between them.

A serial load path lets the tester push any starting state in one bit per cycle. The asynchronous active-low reset clears the register to all zeros. Its release is synchronised to the clock inside the block. Reset outranks the serial load, and the serial load outranks the encoded choice. Any target pattern can be built from any current state in at most WIDTH encoded cycles. On each of those cycles the bit that enters the top must equal the matching target bit.

Top module: `shift_twist_decomp`

## Requirements
- R1: While reset is applied, and after its release, until the first load or encoded step, `pattern` is all zeros and `pattern_valid` is 0. Reset acts at once, without waiting for a clock edge, and outranks `scan_en`.
- R2: With `scan_en`=0, `mode_vld`=1 and `mode_bit`=0 (shift), the next pattern is the old one moved one place toward bit 0. Old bit 0 enters at bit WIDTH-1 unchanged.
- R3: With `scan_en`=0, `mode_vld`=1 and `mode_bit`=1 (twist), the next pattern is the old one moved one place toward bit 0. The inverse of old bit 0 enters at bit WIDTH-1.
- R4: With `scan_en`=0 and `mode_vld`=0, the pattern holds, whatever `mode_bit` and `scan_in` are, and `pattern_valid` is 0 in the following cycle.
- R5: With `scan_en`=1, the next pattern is the old one moved one place toward bit 0, with `scan_in` entering at bit WIDTH-1. `mode_vld` and `mode_bit` are ignored, and `pattern_valid` is 0 in the following cycle.
- R6: `pattern_valid` is 1 in exactly those cycles whose pattern was produced by an encoded shift or twist at the previous clock edge.
- R7: Starting from all zeros, 2*WIDTH consecutive twists pass through 2*WIDTH distinct patterns. The pattern is all ones after WIDTH twists and all zeros again after 2*WIDTH twists.
- R8: From any loaded state, any target pattern is reached in WIDTH encoded steps. Step i (i = 0 first) selects twist exactly when the current bit 0 differs from target bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| scan_en | input | 1 | Serial load select, takes priority over the encoded bit |
| scan_in | input | 1 | Serial load data, enters at bit WIDTH-1 |
| mode_vld | input | 1 | Strobe: `mode_bit` carries an encoded choice this cycle |
| mode_bit | input | 1 | Encoded choice: 1 twist, 0 shift |
| pattern | output | WIDTH | Test pattern driven to the core inputs |
| pattern_valid | output | 1 | High for the cycle after an encoded update |

## Verification
The step assertions assume that `scan_en`, `mode_vld`, `mode_bit` and `scan_in` are known, stable values at every rising edge after the internal reset has been released. They compare the pattern with its value one cycle earlier, so they rely on no input changing near the edge. The stimulus drives every input to a defined level from time zero and changes inputs only on the falling edge. It also holds the encoded strobe low while the release works through the synchroniser.

// File: rtl/shift_twist_pkg.sv
package shift_twist_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_TWIST = 2'd2,
    OP_LOAD  = 2'd3
  } ring_op_e;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ring_next_state.sv
module ring_next_state
  import shift_twist_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic             mode_vld,
  input  logic             mode_bit,
  output logic [WIDTH-1:0] nxt,
  output logic             load,
  output logic             step
);
  ring_op_e op;
  logic     feed;

  always_comb begin
    op = OP_HOLD;
    if (scan_en)       op = OP_LOAD;
    else if (mode_vld) op = mode_bit ? OP_TWIST : OP_SHIFT;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  feed = scan_in;
      OP_TWIST: feed = ~cur[0];
      OP_SHIFT: feed = cur[0];
      default:  feed = cur[0];
    endcase
  end

  assign nxt  = {feed, cur[WIDTH-1:1]};
  assign load = (op != OP_HOLD);
  assign step = (op == OP_SHIFT) || (op == OP_TWIST);
endmodule

// File: rtl/shift_twist_decomp.sv
module shift_twist_decomp #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic             mode_vld,
  input  logic             mode_bit,
  output logic [WIDTH-1:0] pattern,
  output logic             pattern_valid
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] pattern_q;
  logic [WIDTH-1:0] pattern_d;
  logic             load_en;
  logic             step_en;
  logic             valid_q;

  ring_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ring_next_state #(.WIDTH(WIDTH)) u_next (
    .cur      (pattern_q),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .mode_vld (mode_vld),
    .mode_bit (mode_bit),
    .nxt      (pattern_d),
    .load     (load_en),
    .step     (step_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pattern_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      if (load_en) pattern_q <= pattern_d;
      valid_q <= step_en;
    end
  end

  assign pattern       = pattern_q;
  assign pattern_valid = valid_q;

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_en && mode_vld && !mode_bit) |=>
      (pattern_q == {$past(pattern_q[0]), $past(pattern_q[WIDTH-1:1])}));

  // R3
  twist_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_en && mode_vld && mode_bit) |=>
      (pattern_q == {~$past(pattern_q[0]), $past(pattern_q[WIDTH-1:1])}));

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_en && !mode_vld) |=> ($stable(pattern_q) && !valid_q));

  // R5
  scan_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_en |=> ((pattern_q == {$past(scan_in), $past(pattern_q[WIDTH-1:1])}) && !valid_q));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!scan_en && mode_vld) |=> valid_q);
endmodule

// File: tb/shift_twist_decomp_bench.sv
module shift_twist_decomp_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_en = 1'b0;
  logic         scan_in = 1'b0;
  logic         mode_vld = 1'b0;
  logic         mode_bit = 1'b0;
  logic [W-1:0] pattern;
  logic         pattern_valid;

  logic [W-1:0] model;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  shift_twist_decomp #(.WIDTH(W)) u_shift_twist_decomp (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_en       (scan_en),
    .scan_in       (scan_in),
    .mode_vld      (mode_vld),
    .mode_bit      (mode_bit),
    .pattern       (pattern),
    .pattern_valid (pattern_valid)
  );

  // {scan_en, scan_in, mode_vld, mode_bit}
  localparam logic [3:0] VEC [0:15] = '{
    4'b0011, 4'b0011, 4'b0011, 4'b0010, 4'b0010, 4'b0001, 4'b0011, 4'b1111,
    4'b1010, 4'b0010, 4'b0011, 4'b0001, 4'b0100, 4'b0011, 4'b0010, 4'b0011
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive at falling edge, model, clock, sample at next falling edge
  task automatic apply(input logic se, input logic si, input logic mv, input logic mb);
    string tag;
    logic  exp_valid;
    scan_en = se; scan_in = si; mode_vld = mv; mode_bit = mb;
    if (se) begin
      model = {si, model[W-1:1]}; exp_valid = 1'b0; tag = "R5 load";
    end else if (mv) begin
      model = {model[0] ^ mb, model[W-1:1]}; exp_valid = 1'b1;
      tag = mb ? "R3 twist" : "R2 shift";
    end else begin
      exp_valid = 1'b0; tag = "R4 hold";
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, 64'(pattern), 64'(model));
    check({tag, " R6 valid"}, 64'(pattern_valid), 64'(exp_valid));
  endtask

  task automatic idle();
    scan_en = 1'b0; scan_in = 1'b0; mode_vld = 1'b0; mode_bit = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model = '0;
    @(negedge clk);
    check("R1 reset pattern", 64'(pattern), 64'h0);
    check("R1 reset valid", 64'(pattern_valid), 64'h0);
    do_reset();
    check("R1 after release", 64'(pattern), 64'h0);
    check("R1 valid after release", 64'(pattern_valid), 64'h0);

    // vector table
    for (int i = 0; i < 16; i++) apply(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R4: idle with changing data lines
    apply(1'b0, 1'b1, 1'b0, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 1'b0);

    // R3 directed: three twists from zero give 111 at the top
    do_reset();
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b0, 1'b1, 1'b1);
    check("R3 three twists", 64'(pattern), 64'hE0);

    // R7: full Johnson cycle
    do_reset();
    for (int i = 1; i <= 2 * W; i++) begin
      apply(1'b0, 1'b0, 1'b1, 1'b1);
      if (i == W) check("R7 all ones at WIDTH", 64'(pattern), 64'hFF);
      else if (i < 2 * W) check("R7 nonzero inside cycle", 64'(pattern == '0), 64'h0);
      else check("R7 zero after 2*WIDTH", 64'(pattern), 64'h0);
    end

    // R8: reachability in WIDTH steps from loaded seeds
    begin
      logic [W-1:0] seeds   [0:2];
      logic [W-1:0] targets [0:2];
      seeds[0] = 8'hA5; targets[0] = 8'h3C;
      seeds[1] = 8'hFF; targets[1] = 8'h00;
      seeds[2] = 8'h01; targets[2] = 8'h80;
      for (int k = 0; k < 3; k++) begin
        for (int b = 0; b < W; b++) apply(1'b1, seeds[k][b], 1'b1, 1'b0);
        check("R5 seed loaded", 64'(pattern), 64'(seeds[k]));
        for (int b = 0; b < W; b++) apply(1'b0, 1'b0, 1'b1, model[0] ^ targets[k][b]);
        check("R8 target reached", 64'(pattern), 64'(targets[k]));
      end
    end

    // R1: asynchronous reset mid-run outranks scan load
    apply(1'b1, 1'b1, 1'b0, 1'b0);
    scan_en = 1'b1; scan_in = 1'b1;
    #2 rst_n = 1'b0;
    #1 check("R1 async clear", 64'(pattern), 64'h0);
    @(posedge clk);
    @(negedge clk);
    check("R1 reset beats scan", 64'(pattern), 64'h0);
    check("R1 valid in reset", 64'(pattern_valid), 64'h0);
    do_reset();
    check("R1 clear after reset", 64'(pattern), 64'h0);

    done = 1'b1;
    finish_run();
  end
endmodule